// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns each into a request for a parent interrupt controller. Every pin is resynchronized, then judged against a per-pin trigger code (falling edge, rising edge, both edges, low level or high level). A matching condition latches a pending flag. A pin raises its request when its flag is pending, the pin is unmasked, and its priority field is nonzero. The requests leave both as one line per pin and as a single OR-ed line for a parent that has only one input.

Software reaches the block through a plain single-cycle register port with five addresses: trigger codes, priority fields, pending flags, a write-only mask-set port and a write-only mask-clear port. Pin 0 always sits at the most significant end of each register. Pending flags are acknowledged by writing a word with a zero in the flag's position.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every pin is masked, the trigger word (address 0) and priority word (address 1) read 0, the pending word (address 2) reads 0, and `irq_req` and `irq_shared` are low.
- R2: A pin change is seen in the pending flag after exactly three rising clock edges: two synchronizer stages, then the flag register.
- R3: Edge codes: 0 sets pending on a falling edge, 1 on a rising edge, 4 on either edge; the flag stays set after the pin returns, and the opposite edge does nothing under codes 0 and 1.
- R4: Level codes: under 2 (active low) and 3 (active high) the pending flag follows the synchronized level one edge later, and a clearing write does not drop it while the level is active.
- R5: Codes 5 to 15 never set a pending flag, whatever the pin does.
- R6: The trigger field of pin k lies at bits [32-(k+1)*SENSE_W +: SENSE_W] of address 0, and its 4-bit priority field at bits [28-4k +: 4] of address 1; both read back as written.
- R7: The pending flag of pin k reads at bit SRC_W-1-k of address 2 (bit 7-k by default). Writing address 2 clears each flag whose bit is 0 and keeps each whose bit is 1; an all-zero write clears all. A trigger in the same cycle wins over the clear.
- R8: Writing address 3 with a 1 at bit SRC_W-1-k masks pin k from the next cycle; zero bits have no effect; the address reads 0. Masking leaves the pending flag untouched.
- R9: Writing address 4 with a 1 at bit SRC_W-1-k unmasks pin k; zero bits have no effect.
- R10: A priority field of zero blocks the pin's request; any nonzero value lets it through.
- R11: `irq_req[k]` is high exactly when pin k is pending, unmasked and has nonzero priority; `irq_shared` is the OR of all `irq_req` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous interrupt pins, bit k is pin k |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address (0 trigger, 1 priority, 2 pending, 3 mask-set, 4 mask-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| irq_req | output | NUM_PINS | Per-pin request to the parent |
| irq_shared | output | 1 | OR of all per-pin requests |

## Verification
Pin stimulus changes on a falling clock edge, and the pending flag is due after the third rising edge that follows; the bench samples one time unit after the second edge to see it still clear and after the third to see it set. Register writes take effect at the rising edge that ends the write cycle, so mask, priority and clear results are read just after that edge, and a level trigger enabled by a trigger-code write shows one edge later. Reads are combinational and are taken after the address settles, away from any edge.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;

  localparam int PRIO_W = 4;
  localparam int REG_W  = 32;

  localparam logic [2:0] RA_SENSE = 3'd0;
  localparam logic [2:0] RA_PRIO  = 3'd1;
  localparam logic [2:0] RA_SRC   = 3'd2;
  localparam logic [2:0] RA_MSET  = 3'd3;
  localparam logic [2:0] RA_MCLR  = 3'd4;

  // Low bit of the field of pin k; pin 0 sits at the top of the word.
  function automatic int fld_lsb(input int k, input int w);
    return REG_W - (k + 1) * w;
  endfunction

  // Bit of pin k in the one-bit-per-pin registers.
  function automatic int src_pos(input int k, input int srcw);
    return srcw - 1 - k;
  endfunction

  // Trigger condition for one pin from its code and two synchronized samples.
  function automatic logic sense_hit(input logic [3:0] code, input logic now,
                                     input logic was);
    case (code)
      4'd0:    return was & ~now;
      4'd1:    return ~was & now;
      4'd2:    return ~now;
      4'd3:    return now;
      4'd4:    return was ^ now;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_level_code(input logic [3:0] code);
    return (code == 4'd2) || (code == 4'd3);
  endfunction

endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/1ps
module extirq_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/extirq_pend_cell.sv
`timescale 1ns/1ps
module extirq_pend_cell import extirq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_now,
  input  logic       lvl_was,
  input  logic [3:0] code,
  input  logic       clr_req,
  output logic       hit,
  output logic       is_level,
  output logic       pend
);
  logic code_dead;

  assign hit       = sense_hit(code, lvl_now, lvl_was);
  assign is_level  = is_level_code(code);
  assign code_dead = (code > 4'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (is_level) pend <= hit;
    else if (hit)      pend <= 1'b1;
    else if (clr_req)  pend <= 1'b0;
  end

  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && hit) |=> pend);

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_level |=> (pend == $past(hit)));

  // R5
  dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_dead && !pend) |=> !pend);
endmodule

// File: rtl/extirq_regs.sv
`timescale 1ns/1ps
module extirq_regs import extirq_pkg::*; #(
  parameter int N    = 8,
  parameter int SW   = 4,
  parameter int SRCW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wen,
  input  logic [2:0]             bus_addr,
  input  logic [REG_W-1:0]       bus_wdata,
  input  logic [N-1:0]           pend,
  output logic [REG_W-1:0]       bus_rdata,
  output logic [N-1:0][SW-1:0]   sense_f,
  output logic [N-1:0][PRIO_W-1:0] prio_f,
  output logic [N-1:0]           mask_q,
  output logic [N-1:0]           src_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_f <= '0;
      prio_f  <= '0;
      mask_q  <= '1;
    end else if (bus_wen) begin
      case (bus_addr)
        RA_SENSE: for (int k = 0; k < N; k++)
                    sense_f[k] <= bus_wdata[fld_lsb(k, SW) +: SW];
        RA_PRIO:  for (int k = 0; k < N; k++)
                    prio_f[k] <= bus_wdata[fld_lsb(k, PRIO_W) +: PRIO_W];
        RA_MSET:  for (int k = 0; k < N; k++)
                    if (bus_wdata[src_pos(k, SRCW)]) mask_q[k] <= 1'b1;
        RA_MCLR:  for (int k = 0; k < N; k++)
                    if (bus_wdata[src_pos(k, SRCW)]) mask_q[k] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < N; k++)
      src_clr[k] = bus_wen && (bus_addr == RA_SRC) && !bus_wdata[src_pos(k, SRCW)];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_SENSE: for (int k = 0; k < N; k++)
                  bus_rdata[fld_lsb(k, SW) +: SW] = sense_f[k];
      RA_PRIO:  for (int k = 0; k < N; k++)
                  bus_rdata[fld_lsb(k, PRIO_W) +: PRIO_W] = prio_f[k];
      RA_SRC:   for (int k = 0; k < N; k++)
                  bus_rdata[src_pos(k, SRCW)] = pend[k];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/extirq_ctrl.sv
`timescale 1ns/1ps
module extirq_ctrl import extirq_pkg::*; #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wen,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                irq_shared
);
  logic [NUM_PINS-1:0]               lvl_now, lvl_was;
  logic [NUM_PINS-1:0]               pend, hit, is_level, src_clr, mask_q, prio_nz;
  logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_f;
  logic [NUM_PINS-1:0][PRIO_W-1:0]   prio_f;

  extirq_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_was <= '0;
    else        lvl_was <= lvl_now;
  end

  extirq_regs #(.N(NUM_PINS), .SW(SENSE_W), .SRCW(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(pend), .bus_rdata(bus_rdata),
    .sense_f(sense_f), .prio_f(prio_f), .mask_q(mask_q), .src_clr(src_clr));

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    extirq_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .lvl_now(lvl_now[k]), .lvl_was(lvl_was[k]),
      .code(4'(sense_f[k])), .clr_req(src_clr[k]), .hit(hit[k]),
      .is_level(is_level[k]), .pend(pend[k]));

    assign prio_nz[k] = |prio_f[k];
    assign irq_req[k] = pend[k] & ~mask_q[k] & prio_nz[k];

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == RA_MSET && bus_wdata[src_pos(k, SRC_W)]) |=> !irq_req[k]);

    // R7
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == RA_SRC && !bus_wdata[src_pos(k, SRC_W)]
       && !hit[k] && !is_level[k]) |=> !pend[k]);
  end

  assign irq_shared = |irq_req;
endmodule

// File: tb/tb_extirq_ctrl.sv
`timescale 1ns/1ps
module tb_extirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req;
  logic        irq_shared;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extirq_ctrl dut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_shared(irq_shared));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic setpin(input int k, input logic v);
    @(negedge clk); pin_in[k] = v;
  endtask

  // Trigger word: pin p gets 'code', the others 'rest'; pin p field at bits 31-4p..28-4p.
  function automatic logic [31:0] fill(input int p, input logic [3:0] code,
                                       input logic [3:0] rest);
    logic [31:0] w = '0;
    for (int i = 0; i < 8; i++) w[31-4*i -: 4] = (i == p) ? code : rest;
    return w;
  endfunction

  task automatic chk_src(input string tag, input logic [31:0] exp);
    logic [31:0] d; rd(3'd2, d); chk(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 trigger word", d, 0);
    rd(3'd1, d); chk("R1 priority word", d, 0);
    chk_src("R1 pending word", 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_shared", irq_shared, 0);
  endtask

  task automatic t_falling();
    setpin(0, 1); tick(3);
    chk_src("R3 rise ignored under falling code", 0);
    setpin(0, 0); tick(2);
    chk_src("R2 not yet pending after two edges", 0);
    tick(1);
    chk_src("R2 pending after third edge", 32'h80);
    chk("R1 masked pin gives no request", irq_req, 0);
    wr(3'd2, 32'h7F);
    chk_src("R7 clear pin0", 0);
  endtask

  task automatic t_rising();
    wr(3'd0, fill(3, 1, 5));
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFF);
    setpin(3, 1); tick(2);
    chk_src("R2 rising not yet", 0);
    tick(1);
    chk_src("R3 rising pending bit4", 32'h10);
    chk("R11 irq_req pin3", irq_req, 8'h08);
    chk("R11 irq_shared", irq_shared, 1);
    setpin(3, 0); tick(3);
    chk_src("R3 flag held after return", 32'h10);
    wr(3'd2, 32'hFF);
    chk_src("R7 ones keep flag", 32'h10);
    wr(3'd2, 32'hEF);
    chk_src("R7 zero bit clears", 0);
    chk("R11 request drops", irq_req, 0);
    chk("R11 shared drops", irq_shared, 0);
  endtask

  task automatic t_both();
    wr(3'd0, fill(5, 4, 5));
    setpin(5, 1); tick(3);
    chk_src("R3 both: rise", 32'h04);
    wr(3'd2, 32'hFB);
    chk_src("R7 clear pin5", 0);
    setpin(5, 0); tick(3);
    chk_src("R3 both: fall", 32'h04);
    wr(3'd2, 32'hFB);
  endtask

  task automatic t_dead();
    wr(3'd0, fill(2, 9, 5));
    setpin(2, 1); tick(3);
    chk_src("R5 unused code rise", 0);
    setpin(2, 0); tick(3);
    chk_src("R5 unused code fall", 0);
    chk("R5 no request", irq_req, 0);
  endtask

  task automatic t_level();
    wr(3'd0, fill(7, 3, 5));
    setpin(7, 1); tick(3);
    chk_src("R4 high level pending", 32'h01);
    chk("R11 pin7 request", irq_req, 8'h80);
    wr(3'd2, 32'hFE);
    chk_src("R4 clear ignored while active", 32'h01);
    setpin(7, 0); tick(3);
    chk_src("R4 follows level down", 0);
    wr(3'd0, fill(6, 2, 5));
    chk_src("R4 low level not before next edge", 0);
    tick(1);
    chk_src("R4 low level pending", 32'h02);
    setpin(6, 1); tick(3);
    chk_src("R4 low level released", 0);
    setpin(6, 0); tick(3);
    chk_src("R4 low level again", 32'h02);
    wr(3'd0, fill(0, 5, 5));
    wr(3'd2, 32'hFD);
    chk_src("R7 clear after leaving level", 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(3'd0, fill(3, 1, 5));
    setpin(3, 1); tick(3);
    chk("R11 request before mask", irq_req, 8'h08);
    wr(3'd3, 32'h10);
    chk("R8 masked", irq_req, 0);
    chk("R8 shared masked", irq_shared, 0);
    chk_src("R8 pending untouched", 32'h10);
    wr(3'd4, 32'h00);
    chk("R9 zero write no effect", irq_req, 0);
    wr(3'd4, 32'hEF);
    chk("R9 other bits no effect", irq_req, 0);
    wr(3'd4, 32'h10);
    chk("R9 unmask", irq_req, 8'h08);
    wr(3'd3, 32'h00);
    chk("R8 zero write no effect", irq_req, 8'h08);
    rd(3'd3, d); chk("R8 mask-set reads zero", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(3'd1, 32'hFFF0_FFFF);
    chk("R10 zero priority blocks", irq_req, 0);
    rd(3'd1, d); chk("R6 priority readback", d, 32'hFFF0_FFFF);
    wr(3'd1, 32'h0001_0000);
    chk("R10 nonzero priority enables", irq_req, 8'h08);
    rd(3'd0, d); chk("R6 trigger readback", d, fill(3, 1, 5));
  endtask

  task automatic t_clear_all();
    wr(3'd0, 32'h1000_0000 | 32'h0000_0000 | (fill(3, 0, 5) & 32'h0FFF_FFFF));
    @(negedge clk); pin_in[3] = 1'b0; pin_in[0] = 1'b1;
    tick(3);
    chk_src("R3 two pins pending", 32'h90);
    wr(3'd2, 32'h0);
    chk_src("R7 all-zero write clears all", 0);
    chk("R7 no requests", irq_req, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5 rst_n = 1'b1;
    tick(1);
    t_reset();
    t_falling();
    t_rising();
    t_both();
    t_dead();
    t_level();
    t_mask();
    t_prio();
    t_clear_all();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule